// File: doc/BRIEF.md
# Single-Outstanding Interrupt Concentrator

This block collects 64 level-sensitive interrupt lines and presents at most one of them at a time as a pending request. The request is given both as a 6-bit index and as a 64-bit one-hot vector. Lines 0 to 31 come from expansion slots. Each group of four consecutive slot lines shares one mapping register. Lines 32 to 63 are on-board sources, and each of them has a mapping register of its own. Bit 31 of every mapping register is an enable that gates its line or lines.

A request, once chosen, stays pending until software removes it. Software removes it either by writing the matching clear register or by writing the owning mapping register with its enable cleared. The line's input going low does not remove it. When the request is removed, or whenever no request is pending, the block picks the next one by a fixed scan. The scan takes the lowest-numbered qualifying slot line first and the lowest-numbered qualifying on-board line after that.

A single-cycle write port and a combinational read port give access to the registers. Each register sits in an 8-byte slot, and only the upper word (byte offset +4) is live. The register address is 12 bits. Bits 11:8 select the region: 0 is the slot map, 1 is the on-board map, 2 is the slot clear and 3 is the on-board clear. For slot regions, bits 5:3 give the group and bits 7:6 must be zero. For on-board regions, bits 7:3 give the line.

Top module: `irqc_top`

## Requirements
- R1: While rst is high and on the cycle after it, req_valid is 0. After reset every enable bit reads back as 0.
- R2: A read with addr[2]=1 of slot map g returns {enable, 31'(0x7C0 + 4*g)}, and of on-board map k returns {enable, 31'(0x7E0 + k)}. A read with addr[2]=0, or of either clear region, returns 0.
- R3: A write with addr[2]=1 to a map register changes only its bit 31 (the enable) from wdata[31]. A write with addr[2]=0, or outside the four regions, has no effect.
- R4: Slot line n is eligible only while the enable of slot map n/4 is 1. On-board line n is eligible only while the enable of on-board map n-32 is 1.
- R5: When a new request is chosen, it is the lowest-numbered eligible slot line whose latched input is 1. If there is none, it is the lowest-numbered eligible on-board line.
- R6: irq_in is latched on a clock edge, and a request chosen from it appears on the next edge. That is two edges after the input is driven.
- R7: A pending request keeps its index while no cancelling write occurs, even if its input falls or a lower-numbered line becomes eligible.
- R8: Writing a map register with wdata[31]=0 cancels the pending request if that register gates the pending line. A new request is then chosen in the same cycle using the updated enables.
- R9: A slot clear write for group g cancels the pending request when the request is a slot line with index/4 = g. Other slot clear writes have no effect. After a cancel, the next request is chosen in the same cycle.
- R10: An on-board clear write for line k cancels the pending request only if its index is exactly 32+k. After a cancel, the next request is chosen in the same cycle.
- R11: req_vec has bit req_idx set and no other bit when req_valid is 1, and is all zeros when req_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| req_valid | output | 1 | A request is pending |
| req_idx | output | 6 | Index of the pending line |
| req_vec | output | 64 | One-hot form of the pending request |

## Verification
The assertions take irq_in as already synchronous to clk. They also assume that every write is a single-cycle strobe, and that a request can only be removed in a cycle that carries a write. The bench drives all inputs on the falling edge. It issues writes as one-cycle pulses spread over all four regions, both halves of each slot and unused regions, and holds irq_in stable across each rising edge. The reference model therefore sees exactly the values the block latches.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int N_GRP    = 8;
    localparam int GRP_SZ   = 4;
    localparam int N_SLOT   = N_GRP * GRP_SZ;
    localparam int N_BRD    = 32;
    localparam int N_IRQ    = N_SLOT + N_BRD;
    localparam int IDX_W    = $clog2(N_IRQ);
    localparam int GSEL_W   = $clog2(N_GRP);
    localparam int BSEL_W   = $clog2(N_BRD);
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam logic [11:0] MAP_BASE = 12'h7C0;

    typedef enum logic [1:0] {
        RG_SLOT_MAP = 2'd0,
        RG_BRD_MAP  = 2'd1,
        RG_SLOT_CLR = 2'd2,
        RG_BRD_CLR  = 2'd3
    } region_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } req_t;

    typedef struct packed {
        logic              hit;
        region_e           rg;
        logic [BSEL_W-1:0] sel;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.rg  = region_e'(a[9:8]);
        d.sel = a[7:3];
        d.hit = (a[11:10] == 2'b00) &&
                ((d.rg == RG_BRD_MAP) || (d.rg == RG_BRD_CLR) || (a[7:6] == 2'b00));
        return d;
    endfunction

    function automatic logic [DATA_W-2:0] slot_low(input logic [GSEL_W-1:0] g);
        return (DATA_W-1)'(MAP_BASE) | ((DATA_W-1)'(g) << 2);
    endfunction

    function automatic logic [DATA_W-2:0] brd_low(input logic [BSEL_W-1:0] k);
        return (DATA_W-1)'(MAP_BASE) + (DATA_W-1)'(32) + (DATA_W-1)'(k);
    endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  req_t              cur,
    output logic [N_GRP-1:0]  en_slot,
    output logic [N_BRD-1:0]  en_brd,
    output logic [N_GRP-1:0]  en_slot_nxt,
    output logic [N_BRD-1:0]  en_brd_nxt,
    output logic              cancel,
    output logic [DATA_W-1:0] rdata
);
    dec_t d;
    logic live_wr;
    logic cur_slot_grp_hit;
    logic cur_brd_hit;

    assign d       = decode(addr);
    assign live_wr = wr && addr[2] && d.hit;

    assign cur_slot_grp_hit = cur.valid && !cur.idx[IDX_W-1] &&
                              (cur.idx[IDX_W-2 -: GSEL_W] == d.sel[GSEL_W-1:0]);
    assign cur_brd_hit      = cur.valid && cur.idx[IDX_W-1] &&
                              (cur.idx[BSEL_W-1:0] == d.sel);

    always_comb begin
        en_slot_nxt = en_slot;
        en_brd_nxt  = en_brd;
        cancel      = 1'b0;
        if (live_wr) begin
            unique case (d.rg)
                RG_SLOT_MAP: begin
                    en_slot_nxt[d.sel[GSEL_W-1:0]] = wdata[DATA_W-1];
                    cancel = !wdata[DATA_W-1] && cur_slot_grp_hit;
                end
                RG_BRD_MAP: begin
                    en_brd_nxt[d.sel] = wdata[DATA_W-1];
                    cancel = !wdata[DATA_W-1] && cur_brd_hit;
                end
                RG_SLOT_CLR: cancel = cur_slot_grp_hit;
                RG_BRD_CLR:  cancel = cur_brd_hit;
                default:     cancel = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_slot <= '0;
            en_brd  <= '0;
        end else begin
            en_slot <= en_slot_nxt;
            en_brd  <= en_brd_nxt;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr[2] && d.hit) begin
            if (d.rg == RG_SLOT_MAP)
                rdata = {en_slot[d.sel[GSEL_W-1:0]], slot_low(d.sel[GSEL_W-1:0])};
            else if (d.rg == RG_BRD_MAP)
                rdata = {en_brd[d.sel], brd_low(d.sel)};
        end
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
(
    input  logic [N_IRQ-1:0] lines,
    input  logic [N_GRP-1:0] en_slot,
    input  logic [N_BRD-1:0] en_brd,
    output logic [N_IRQ-1:0] gate,
    output req_t             pick
);
    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        assign gate[i] = en_slot[i / GRP_SZ];
    end
    for (genvar k = 0; k < N_BRD; k++) begin : g_brd
        assign gate[N_SLOT + k] = en_brd[k];
    end

    logic [N_IRQ-1:0] cand;
    assign cand = lines & gate;

    always_comb begin
        pick = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       irq_in,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              req_valid,
    output logic [5:0]        req_idx,
    output logic [63:0]       req_vec
);
    logic [N_IRQ-1:0] irq_q;
    logic [N_IRQ-1:0] gate_nxt;
    logic [N_IRQ-1:0] gate_q;
    logic [N_GRP-1:0] en_slot, en_slot_nxt;
    logic [N_BRD-1:0] en_brd, en_brd_nxt;
    logic             cancel;
    req_t             cur, pick;

    irqc_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cur(cur), .en_slot(en_slot), .en_brd(en_brd),
        .en_slot_nxt(en_slot_nxt), .en_brd_nxt(en_brd_nxt),
        .cancel(cancel), .rdata(reg_rdata)
    );

    irqc_pick u_pick (
        .lines(irq_q), .en_slot(en_slot_nxt), .en_brd(en_brd_nxt),
        .gate(gate_nxt), .pick(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= '0;
            cur    <= '0;
            gate_q <= '0;
        end else begin
            irq_q  <= irq_in;
            gate_q <= gate_nxt;
            if (!cur.valid || cancel)
                cur <= pick;
        end
    end

    assign req_valid = cur.valid;
    assign req_idx   = cur.idx;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_vec
        assign req_vec[i] = cur.valid && (cur.idx == IDX_W'(i));
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic        req_valid,
    input logic [5:0]  req_idx,
    input logic [63:0] req_vec,
    input logic [63:0] irq_q,
    input logic [63:0] gate_q
);
    logic        prev_valid;
    logic [63:0] prev_irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_valid <= 1'b0;
            prev_irq   <= '0;
        end else begin
            prev_valid <= req_valid;
            prev_irq   <= irq_q;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !req_valid); // R1

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !reg_wr) |=> (req_valid && $stable(req_idx))); // R7

    AST_NEW_PICK_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !prev_valid) |-> (prev_irq[req_idx] && gate_q[req_idx])); // R4

    AST_VEC_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(req_vec) == int'(req_valid)); // R11

    AST_VEC_MATCH: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_vec[req_idx]); // R11
endmodule

bind irqc_top irqc_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .req_valid(req_valid),
    .req_idx(req_idx), .req_vec(req_vec), .irq_q(irq_q), .gate_q(gate_q)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [5:0]  req_idx;
    logic [63:0] req_vec;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";

    logic [7:0]  m_en_slot;
    logic [31:0] m_en_brd;
    logic [63:0] m_irq_q;
    logic        m_valid;
    logic [5:0]  m_idx;

    irqc_top u0 (.*);

    always #2.5 clk = ~clk;

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    function automatic logic [6:0] m_pick(input logic [63:0] q, input logic [7:0] es,
                                          input logic [31:0] eb);
        for (int i = 0; i < 64; i++) begin
            logic ok;
            ok = (i < 32) ? es[i/4] : eb[i-32];
            if (q[i] && ok) return {1'b1, 6'(i)};
        end
        return '0;
    endfunction

    task automatic model_step();
        logic       cancel;
        logic [6:0] p;
        logic [3:0] rg;
        int         g, k;
        cancel = 1'b0;
        rg = reg_addr[11:8];
        g  = int'(reg_addr[5:3]);
        k  = int'(reg_addr[7:3]);
        if (reg_wr && reg_addr[2]) begin
            if (rg == 0 && reg_addr[7:6] == 0) begin
                m_en_slot[g] = reg_wdata[31];
                cancel = !reg_wdata[31] && m_valid && m_idx < 32 && int'(m_idx) / 4 == g;
            end else if (rg == 1) begin
                m_en_brd[k] = reg_wdata[31];
                cancel = !reg_wdata[31] && m_valid && int'(m_idx) == 32 + k;
            end else if (rg == 2 && reg_addr[7:6] == 0) begin
                cancel = m_valid && m_idx < 32 && int'(m_idx) / 4 == g;
            end else if (rg == 3) begin
                cancel = m_valid && int'(m_idx) == 32 + k;
            end
        end
        if (!m_valid || cancel) begin
            p = m_pick(m_irq_q, m_en_slot, m_en_brd);
            m_valid = p[6];
            m_idx   = p[6] ? p[5:0] : m_idx;
        end
        m_irq_q = irq_in;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({tag, " req_valid"}, 64'(req_valid), 64'(m_valid));
        if (m_valid) check({tag, " req_idx"}, 64'(req_idx), 64'(m_idx));
        check("R11 req_vec", req_vec, m_valid ? (64'd1 << m_idx) : 64'd0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string t, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        check(t, 64'(reg_rdata), 64'(exp));
    endtask

    function automatic logic [11:0] a_smap(input int g); return 12'h004 | 12'(g << 3); endfunction
    function automatic logic [11:0] a_bmap(input int k); return 12'h104 | 12'(k << 3); endfunction
    function automatic logic [11:0] a_sclr(input int g); return 12'h204 | 12'(g << 3); endfunction
    function automatic logic [11:0] a_bclr(input int k); return 12'h304 | 12'(k << 3); endfunction

    initial begin
        void'($urandom(32'h1234_5678));
        m_en_slot = '0; m_en_brd = '0; m_irq_q = '0; m_valid = 1'b0; m_idx = '0;
        irq_in = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1 reset req_valid", 64'(req_valid), 64'd0);
        rst = 1'b0;
        irq_in = '0;
        tick();
        check("R1 after reset", 64'(req_valid), 64'd0);
        m_irq_q = '0;

        tag = "R2";
        for (int g = 0; g < 8; g++) rd("R1 R2 slot map read", a_smap(g), 32'h7C0 | 32'(g << 2));
        for (int k = 0; k < 32; k++) rd("R1 R2 board map read", a_bmap(k), 32'h7E0 + 32'(k));
        rd("R2 base word read", 12'h000, 32'd0);
        rd("R2 clear region read", a_sclr(1), 32'd0);

        tag = "R3";
        wr(12'h008, 32'hFFFF_FFFF);
        rd("R3 base word write ignored", a_smap(1), 32'h7C4);
        wr(12'hC0C, 32'hFFFF_FFFF);
        rd("R3 outside region ignored", a_smap(1), 32'h7C4);
        wr(a_smap(2), 32'hDEAD_BEEF);
        rd("R3 only enable bit written", a_smap(2), 32'h8000_07C8);
        wr(a_smap(2), 32'h0000_0000);
        rd("R3 enable cleared", a_smap(2), 32'h7C8);

        tag = "R6";
        wr(a_smap(0), 32'h8000_0000);
        irq_in[3] = 1'b1;
        tick();
        check("R6 not yet after one edge", 64'(req_valid), 64'd0);
        tick();
        check("R6 request after two edges", 64'(req_valid), 64'd1);
        check("R6 idx", 64'(req_idx), 64'd3);

        tag = "R7";
        irq_in[3] = 1'b0; irq_in[0] = 1'b1;
        repeat (4) tick();
        check("R7 held idx", 64'(req_idx), 64'd3);

        tag = "R9";
        wr(a_sclr(1), 32'd0);
        check("R9 other group no effect", 64'(req_idx), 64'd3);
        wr(a_sclr(0), 32'd0);
        check("R9 clear repicks line 0", 64'(req_idx), 64'd0);

        tag = "R8";
        wr(a_bmap(5), 32'h8000_0000);
        irq_in[37] = 1'b1;
        tick();
        wr(a_smap(0), 32'h0);
        check("R8 disable cancels, repick board", 64'(req_idx), 64'd37);

        tag = "R10";
        wr(a_bclr(4), 32'd0);
        check("R10 wrong line no effect", 64'(req_idx), 64'd37);
        irq_in[37] = 1'b0;
        tick();
        wr(a_bclr(5), 32'd0);
        check("R10 exact clear cancels", 64'(req_valid), 64'd0);

        tag = "R5";
        wr(a_bmap(0), 32'h8000_0000);
        wr(a_smap(7), 32'h8000_0000);
        irq_in = '0; irq_in[32] = 1'b1; irq_in[31] = 1'b1;
        tick(); tick();
        check("R5 slot line beats board", 64'(req_idx), 64'd31);

        tag = "R4";
        for (int n = 0; n < 3000; n++) begin
            irq_in = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) begin
                logic [11:0] a;
                a = 12'($urandom_range(0, 4)) << 8;
                a[7:3] = 5'($urandom);
                a[2]   = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 1) == 1 && a[11:8] != 1 && a[11:8] != 3) a[7:6] = 2'b00;
                wr(a, $urandom);
            end else begin
                tick();
            end
        end
        for (int g = 0; g < 8; g++) rd("R2 final slot read", a_smap(g), {m_en_slot[g], 31'h7C0 | 31'(g << 2)});
        for (int k = 0; k < 32; k++) rd("R2 final board read", a_bmap(k), {m_en_brd[k], 31'h7E0 + 31'(k)});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule